// File: doc/BRIEF.md
# Context-Switch Microsequencer

This block runs a short stored microprogram that moves a graphics engine's register state into a context memory (save) or back out of it (restore). A host fills a 256-word program store through an index register and a data register that steps forward after every write. A start pulse then runs the program from word 0 until an end command retires.

Each instruction is 24 bits wide, and its class sits in bits 23:20. The program can load a length register and copy that value into the context-memory position pointer. It can move blocks of consecutive register words, branch on a flag, wait for a flag to reach a level, set or clear a flag, and issue control commands. Flag 0 sets the transfer direction. The flags come from three internal banks that the program writes and one external bank of status inputs. The register file and the context memory sit outside the block and return read data in the same cycle.

Top module: `ctxsw_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `reg_we`, `ctx_we`, `swap_pulse` and `current_pulse` are all low.
- R2: A write to the index port sets the store address. Each data-port write stores its word at that address and then advances the address by one.
- R3: A start while idle runs the program from address 0. `busy` goes high in the next cycle and stays high until the end command retires. `done` then pulses for one cycle while `busy` falls. A start while busy has no effect.
- R4: The class field in bits 23:20 selects the instruction. Classes 0, 3 and 8 to 15 each take one cycle and do nothing.
- R5: Class 2 loads the 20-bit length register from bits 19:0. Control command 0xA (bits 3:0 of a class-6 word) copies the length register into the context position pointer.
- R6: Class 1 moves bits 19:14 words, starting at register address bits 13:0. It moves one word per cycle and takes count+1 cycles in all. A count of 0 takes one cycle and makes no access.
- R7: During a transfer, flag 0 equal to 1 copies register words to the context memory (save), and flag 0 equal to 0 copies context words to the registers (load).
- R8: Every word moved advances the context position by one, so consecutive transfers fill contiguous context words.
- R9: Class 4 jumps to bits 15:8 when the flag at bits 6:0 is set (bit 7 = 0) or clear (bit 7 = 1). Otherwise it falls through.
- R10: Class 5 stalls until the flag at bits 6:0 equals bit 7.
- R11: Class 7 writes bit 7 into the flag at bits 6:0. Flags 0 to 95 are internal. Flags 96 to 127 read `ext_flags[index-96]` and ignore writes. Flag 104 always reads 1.
- R12: Control command 0x7 pulses `swap_pulse` and 0x9 pulses `current_pulse`, each for one cycle after the command executes. Command 0xE ends the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_idx_we | input | 1 | Write strobe for the store index |
| prog_idx_wdata | input | 8 | New store index |
| prog_dat_we | input | 1 | Write strobe for a program word |
| prog_dat_wdata | input | 24 | Program word |
| start | input | 1 | Run request |
| ext_flags | input | 32 | External status flags (indices 96 to 127) |
| reg_addr | output | 14 | Register word address |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, same cycle |
| ctx_addr | output | 16 | Context word address (position pointer) |
| ctx_we | output | 1 | Context write strobe |
| ctx_wdata | output | 32 | Context write data |
| ctx_rdata | input | 32 | Context read data, same cycle |
| swap_pulse | output | 1 | Next context becomes the swap target |
| current_pulse | output | 1 | Next context becomes current |
| busy | output | 1 | Program running |
| done | output | 1 | End command retired |

## Verification
The bench builds the block with its default parameters: a 256-word store, 14-bit register and 16-bit context addresses, and three internal flag banks. Its register-file and context-memory models are 256 words deep and decode the low address bits. That depth is enough for transfers of up to 63 words placed anywhere in the window. With the defaults, the full 8-bit branch range and the whole external flag bank are reachable, so the bench can test the hardwired flag, writes to the external bank that must be ignored, and waits on both levels of a live status input.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int INSTR_W = 24;

    localparam logic [3:0] OPC_XFER = 4'd1;
    localparam logic [3:0] OPC_LEN  = 4'd2;
    localparam logic [3:0] OPC_BRA  = 4'd4;
    localparam logic [3:0] OPC_WAIT = 4'd5;
    localparam logic [3:0] OPC_CTRL = 4'd6;
    localparam logic [3:0] OPC_FLAG = 4'd7;

    localparam logic [3:0] CMD_SWAP = 4'h7;
    localparam logic [3:0] CMD_CUR  = 4'h9;
    localparam logic [3:0] CMD_PTR  = 4'hA;
    localparam logic [3:0] CMD_END  = 4'hE;

    localparam logic [6:0] FLAG_DIR    = 7'd0;
    localparam logic [6:0] FLAG_ALWAYS = 7'd104;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [19:0] imm;
        logic [13:0] xbase;
        logic [5:0]  xcnt;
        logic [7:0]  target;
        logic        pol;
        logic [6:0]  flag;
        logic [3:0]  cmd;
    } instr_t;

endpackage

// File: rtl/ctxsw_store.sv
module ctxsw_store
    import ctxsw_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic [AW-1:0]      idx_wdata,
    input  logic               dat_we,
    input  logic [INSTR_W-1:0] dat_wdata,
    input  logic [AW-1:0]      rd_addr,
    output logic [INSTR_W-1:0] rd_data
);

    logic [INSTR_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]      idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (idx_we) begin
            idx_d = idx_wdata;
        end else if (dat_we) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (dat_we && !idx_we) begin
            mem_q[idx_q] <= dat_wdata;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ctxsw_flags.sv
module ctxsw_flags #(
    parameter int INT_BANKS = 3,
    parameter int ALWAYS_IDX = 104,
    localparam int INT_FLAGS = INT_BANKS * 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [6:0]  wr_idx,
    input  logic        wr_val,
    input  logic [6:0]  rd_idx,
    input  logic [31:0] ext_bank,
    output logic        rd_val,
    output logic        dir
);

    logic [INT_FLAGS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_en && (int'(wr_idx) < INT_FLAGS)) begin
            flags_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_comb begin
        if (int'(rd_idx) < INT_FLAGS) begin
            rd_val = flags_q[rd_idx];
        end else if (int'(rd_idx) == ALWAYS_IDX) begin
            rd_val = 1'b1;
        end else if (int'(rd_idx[6:5]) == INT_BANKS) begin
            rd_val = ext_bank[rd_idx[4:0]];
        end else begin
            rd_val = 1'b0;
        end
    end

    assign dir = flags_q[0];

endmodule

// File: rtl/ctxsw_decode.sv
module ctxsw_decode
    import ctxsw_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output instr_t             ins
);

    always_comb begin
        ins.op     = word[23:20];
        ins.imm    = word[19:0];
        ins.xcnt   = word[19:14];
        ins.xbase  = word[13:0];
        ins.target = word[15:8];
        ins.pol    = word[7];
        ins.flag   = word[6:0];
        ins.cmd    = word[3:0];
    end

endmodule

// File: rtl/ctxsw_sequencer.sv
module ctxsw_sequencer
    import ctxsw_pkg::*;
#(
    parameter int STORE_DEPTH = 256,
    parameter int DATA_W = 32,
    parameter int REG_AW = 14,
    parameter int CTX_AW = 16,
    parameter int INT_BANKS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           prog_idx_we,
    input  logic [$clog2(STORE_DEPTH)-1:0] prog_idx_wdata,
    input  logic                           prog_dat_we,
    input  logic [INSTR_W-1:0]             prog_dat_wdata,
    input  logic                           start,
    input  logic [31:0]                    ext_flags,
    output logic [REG_AW-1:0]              reg_addr,
    output logic                           reg_we,
    output logic [DATA_W-1:0]              reg_wdata,
    input  logic [DATA_W-1:0]              reg_rdata,
    output logic [CTX_AW-1:0]              ctx_addr,
    output logic                           ctx_we,
    output logic [DATA_W-1:0]              ctx_wdata,
    input  logic [DATA_W-1:0]              ctx_rdata,
    output logic                           swap_pulse,
    output logic                           current_pulse,
    output logic                           busy,
    output logic                           done
);

    localparam int PC_W = $clog2(STORE_DEPTH);

    typedef struct packed {
        seq_state_e        st;
        logic [PC_W-1:0]   pc;
        logic [19:0]       len;
        logic [CTX_AW-1:0] pos;
        logic [REG_AW-1:0] xreg;
        logic [5:0]        left;
        logic              done;
        logic              swap;
        logic              cur;
    } seq_t;

    seq_t d, q;

    logic [INSTR_W-1:0] word;
    instr_t             ins;
    logic               flag_rd;
    logic               dir_save;
    logic               flag_we;

    ctxsw_store #(.DEPTH(STORE_DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (prog_idx_we),
        .idx_wdata (prog_idx_wdata),
        .dat_we    (prog_dat_we),
        .dat_wdata (prog_dat_wdata),
        .rd_addr   (q.pc),
        .rd_data   (word)
    );

    ctxsw_decode i_decode (
        .word (word),
        .ins  (ins)
    );

    ctxsw_flags #(.INT_BANKS(INT_BANKS), .ALWAYS_IDX(int'(FLAG_ALWAYS))) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (flag_we),
        .wr_idx   (ins.flag),
        .wr_val   (ins.pol),
        .rd_idx   (ins.flag),
        .ext_bank (ext_flags),
        .rd_val   (flag_rd),
        .dir      (dir_save)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.swap  = 1'b0;
        d.cur   = 1'b0;
        flag_we = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st = ST_RUN;
                    d.pc = '0;
                end
            end
            ST_RUN: begin
                d.pc = q.pc + 1'b1;
                case (ins.op)
                    OPC_XFER: begin
                        if (ins.xcnt != '0) begin
                            d.st   = ST_XFER;
                            d.pc   = q.pc;
                            d.xreg = REG_AW'(ins.xbase);
                            d.left = ins.xcnt;
                        end
                    end
                    OPC_LEN: d.len = ins.imm;
                    OPC_BRA: begin
                        if (flag_rd != ins.pol) begin
                            d.pc = PC_W'(ins.target);
                        end
                    end
                    OPC_WAIT: begin
                        if (flag_rd != ins.pol) begin
                            d.pc = q.pc;
                        end
                    end
                    OPC_FLAG: flag_we = 1'b1;
                    OPC_CTRL: begin
                        case (ins.cmd)
                            CMD_SWAP: d.swap = 1'b1;
                            CMD_CUR:  d.cur  = 1'b1;
                            CMD_PTR:  d.pos  = CTX_AW'(q.len);
                            CMD_END: begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
            ST_XFER: begin
                d.xreg = q.xreg + 1'b1;
                d.pos  = q.pos + 1'b1;
                d.left = q.left - 1'b1;
                if (q.left == 6'd1) begin
                    d.st = ST_RUN;
                    d.pc = q.pc + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign reg_addr      = q.xreg;
    assign ctx_addr      = q.pos;
    assign reg_we        = (q.st == ST_XFER) && !dir_save;
    assign ctx_we        = (q.st == ST_XFER) && dir_save;
    assign reg_wdata     = ctx_rdata;
    assign ctx_wdata     = reg_rdata;
    assign busy          = (q.st != ST_IDLE);
    assign done          = q.done;
    assign swap_pulse    = q.swap;
    assign current_pulse = q.cur;

endmodule

// File: rtl/ctxsw_sequencer_chk.sv
module ctxsw_sequencer_chk #(
    parameter int REG_AW = 14,
    parameter int CTX_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              reg_we,
    input logic              ctx_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [CTX_AW-1:0] ctx_addr,
    input logic              swap_pulse,
    input logic              current_pulse
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_we && !ctx_we));

    assert_start_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_on_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_one_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && ctx_we));

    assert_pos_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || ctx_we) && $past(reg_we || ctx_we)) |->
        (ctx_addr == CTX_AW'($past(ctx_addr) + 1'b1)));

    assert_reg_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || ctx_we) && $past(reg_we || ctx_we)) |->
        (reg_addr == REG_AW'($past(reg_addr) + 1'b1)));

    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(swap_pulse && current_pulse));

endmodule

bind ctxsw_sequencer ctxsw_sequencer_chk #(.REG_AW(REG_AW), .CTX_AW(CTX_AW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .reg_we        (reg_we),
    .ctx_we        (ctx_we),
    .reg_addr      (reg_addr),
    .ctx_addr      (ctx_addr),
    .swap_pulse    (swap_pulse),
    .current_pulse (current_pulse)
);

// File: tb/test_ctxsw_sequencer.sv
module test_ctxsw_sequencer;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_idx_we = 1'b0;
    logic [7:0]  prog_idx_wdata = '0;
    logic        prog_dat_we = 1'b0;
    logic [23:0] prog_dat_wdata = '0;
    logic        start = 1'b0;
    logic [31:0] ext_flags = '0;
    logic [13:0] reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata, reg_rdata;
    logic [15:0] ctx_addr;
    logic        ctx_we;
    logic [31:0] ctx_wdata, ctx_rdata;
    logic        swap_pulse, current_pulse, busy, done;

    always #2.5 clk = ~clk;

    ctxsw_sequencer i_ctxsw_sequencer (.*);

    logic [31:0] regm [256];
    logic [31:0] ctxm [256];
    logic [31:0] regs_snap [256];
    logic [31:0] ctxs_snap [256];
    logic [23:0] prog [16];

    assign reg_rdata = regm[reg_addr[7:0]];
    assign ctx_rdata = ctxm[ctx_addr[7:0]];

    always @(posedge clk) begin
        if (reg_we) regm[reg_addr[7:0]] <= reg_wdata;
        if (ctx_we) ctxm[ctx_addr[7:0]] <= ctx_wdata;
    end

    int n_chk = 0;
    int n_bad = 0;
    int busy_cyc, swap_cnt, cur_cnt, wr_cnt;
    bit done_seen;
    int cyc = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (swap_pulse) swap_cnt++;
            if (current_pulse) cur_cnt++;
            if (reg_we || ctx_we) wr_cnt++;
            if (done) done_seen = 1'b1;
        end
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic load_prog(input int base, input int n);
        @(negedge clk);
        prog_idx_we = 1'b1;
        prog_idx_wdata = 8'(base);
        @(negedge clk);
        prog_idx_we = 1'b0;
        for (int i = 0; i < n; i++) begin
            prog_dat_we = 1'b1;
            prog_dat_wdata = prog[i];
            @(negedge clk);
        end
        prog_dat_we = 1'b0;
    endtask

    task automatic kick();
        busy_cyc = 0; swap_cnt = 0; cur_cnt = 0; wr_cnt = 0; done_seen = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done_seen && k < 500) begin
            @(negedge clk);
            k++;
        end
        check(done_seen, req, 32'(k), 32'd0);
        @(negedge clk);
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) begin
            regm[i] = $urandom;
            ctxm[i] = $urandom;
        end
    endtask

    task automatic snap();
        for (int i = 0; i < 256; i++) begin
            regs_snap[i] = regm[i];
            ctxs_snap[i] = ctxm[i];
        end
    endtask

    function automatic logic [23:0] xfer(input int base, input int cnt);
        return 24'h100000 | 24'(cnt << 14) | 24'(base);
    endfunction

    function automatic logic [23:0] bra(input int tgt, input bit pol, input int flag);
        return 24'h400000 | 24'(tgt << 8) | 24'(pol << 7) | 24'(flag);
    endfunction

    initial begin
        void'($urandom(32'd2024));
        fill_random();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !reg_we && !ctx_we && !swap_pulse && !current_pulse,
              "R1 reset idle", {busy, done, reg_we, ctx_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R6 R7: directed save
        prog[0] = 24'h700080; prog[1] = 24'h200010; prog[2] = 24'h60000A;
        prog[3] = xfer(32'h20, 4); prog[4] = 24'h60000E;
        load_prog(0, 5);
        snap();
        kick();
        wait_done("R3 save run ends");
        for (int i = 0; i < 4; i++)
            check(ctxm[16 + i] == regs_snap[32 + i], "R7 save word", ctxm[16 + i], regs_snap[32 + i]);
        check(ctxm[20] == ctxs_snap[20], "R6 save stops at count", ctxm[20], ctxs_snap[20]);
        check(busy_cyc == 9, "R6 save cycles", busy_cyc, 9);

        // R7: directed load
        prog[0] = 24'h700000; prog[1] = 24'h200030; prog[2] = 24'h60000A;
        prog[3] = xfer(32'h50, 6); prog[4] = 24'h60000E;
        load_prog(0, 5);
        snap();
        kick();
        wait_done("R3 load run ends");
        for (int i = 0; i < 6; i++)
            check(regm[80 + i] == ctxs_snap[48 + i], "R7 load word", regm[80 + i], ctxs_snap[48 + i]);

        // R8: contiguous transfers
        prog[0] = 24'h700080; prog[1] = 24'h200040; prog[2] = 24'h60000A;
        prog[3] = xfer(32'h10, 3); prog[4] = xfer(32'h80, 2); prog[5] = 24'h60000E;
        load_prog(0, 6);
        snap();
        kick();
        wait_done("R3 pos run ends");
        check(ctxm[8'h43] == regs_snap[8'h80], "R8 second block start", ctxm[8'h43], regs_snap[8'h80]);
        check(ctxm[8'h44] == regs_snap[8'h81], "R8 second block end", ctxm[8'h44], regs_snap[8'h81]);

        // R6: zero count
        prog[0] = 24'h700080; prog[1] = xfer(32'h20, 0); prog[2] = 24'h60000E;
        load_prog(0, 3);
        kick();
        wait_done("R6 zero run ends");
        check(wr_cnt == 0, "R6 zero count no access", wr_cnt, 0);
        check(busy_cyc == 3, "R6 zero count cycles", busy_cyc, 3);

        // R4: unknown classes
        prog[0] = 24'h800001; prog[1] = 24'h000000; prog[2] = 24'h3FFFFF; prog[3] = 24'h60000E;
        load_prog(0, 4);
        kick();
        wait_done("R4 run ends");
        check(busy_cyc == 4 && wr_cnt == 0, "R4 no-op classes", busy_cyc, 4);

        // R11 R9: write to always-true ignored; branch-if-clear not taken
        prog[0] = 24'h700068; prog[1] = bra(4, 1, 104); prog[2] = 24'h600009;
        prog[3] = 24'h60000E; prog[4] = 24'h600007; prog[5] = 24'h60000E;
        load_prog(0, 6);
        kick();
        wait_done("R11 run ends");
        check(cur_cnt == 1 && swap_cnt == 0, "R11 flag 104 stays set", {cur_cnt[15:0], swap_cnt[15:0]}, 32'h00010000);

        // R11: external bank write ignored
        prog[0] = 24'h7000E0; prog[1] = bra(4, 0, 96); prog[2] = 24'h600009;
        prog[3] = 24'h60000E; prog[4] = 24'h600007; prog[5] = 24'h60000E;
        load_prog(0, 6);
        kick();
        wait_done("R11 ext run ends");
        check(cur_cnt == 1 && swap_cnt == 0, "R11 ext write ignored", {cur_cnt[15:0], swap_cnt[15:0]}, 32'h00010000);

        // R9 R11 R12: set/clear internal flags, branch if set
        prog[0] = 24'h700085; prog[1] = bra(4, 0, 5); prog[2] = 24'h600009; prog[3] = 24'h60000E;
        prog[4] = 24'h600007; prog[5] = 24'h700005; prog[6] = 24'h700006; prog[7] = bra(9, 0, 5);
        prog[8] = 24'h60000E; prog[9] = 24'h600009; prog[10] = 24'h60000E;
        load_prog(0, 11);
        kick();
        wait_done("R9 run ends");
        check(swap_cnt == 1 && cur_cnt == 0, "R9 branch on set then clear", {cur_cnt[15:0], swap_cnt[15:0]}, 32'h00000001);
        check(busy_cyc == 7, "R12 branch path cycles", busy_cyc, 7);

        // R2: index reposition
        prog[0] = bra(7, 0, 104); prog[1] = 24'h60000E;
        load_prog(0, 2);
        prog[0] = 24'h600007; prog[1] = 24'h60000E;
        load_prog(7, 2);
        kick();
        wait_done("R2 run ends");
        check(swap_cnt == 1 && busy_cyc == 3, "R2 words at new index", busy_cyc, 3);

        // R10 R3: wait on clear, restart while stalled ignored
        ext_flags[0] = 1'b1;
        prog[0] = 24'h600009; prog[1] = 24'h500060; prog[2] = 24'h60000E;
        load_prog(0, 3);
        kick();
        repeat (20) @(negedge clk);
        check(busy && !done_seen, "R10 stalls while flag set", busy, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ext_flags[0] = 1'b0;
        wait_done("R10 resumes on clear");
        check(cur_cnt == 1, "R3 start while busy ignored", cur_cnt, 1);

        // R10: wait on set
        prog[0] = 24'h5000E4; prog[1] = 24'h60000E;
        load_prog(0, 2);
        kick();
        repeat (10) @(negedge clk);
        check(busy && !done_seen, "R10 stalls while flag clear", busy, 1);
        ext_flags[4] = 1'b1;
        wait_done("R10 resumes on set");
        ext_flags[4] = 1'b0;

        // R6 R7 R8: random transfers
        for (int it = 0; it < 40; it++) begin
            int dir, cnt, base, pos;
            bit ok;
            dir = int'($urandom % 2);
            cnt = 1 + int'($urandom % 40);
            base = int'($urandom % 200);
            pos = int'($urandom % 200);
            fill_random();
            prog[0] = 24'h700000 | 24'(dir << 7); prog[1] = 24'h200000 | 24'(pos);
            prog[2] = 24'h60000A; prog[3] = xfer(base, cnt); prog[4] = 24'h60000E;
            load_prog(0, 5);
            snap();
            kick();
            wait_done("R6 random run ends");
            ok = 1'b1;
            for (int i = 0; i < cnt; i++) begin
                if (dir == 1 && ctxm[pos + i] != regs_snap[base + i]) ok = 1'b0;
                if (dir == 0 && regm[base + i] != ctxs_snap[pos + i]) ok = 1'b0;
            end
            check(ok, dir == 1 ? "R7 random save" : "R7 random load", 32'(it), 32'(cnt));
            check(busy_cyc == 5 + cnt && wr_cnt == cnt, "R8 random cycles", busy_cyc, 32'(5 + cnt));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule